// File: doc/BRIEF.md
# Unified Multi-Port Reservation Station

This block is the waiting room between renaming and execution in an out-of-order core. It holds up to twenty micro-operations in one pool that every execution unit shares. The allocator writes up to two entries per cycle. Each entry carries an operation class, an opcode, a destination tag and two source operands. Each source is either a value that is already known or the tag of the result it is waiting for. A result bus returns one tagged value per cycle, and every waiting entry whose source tag matches that tag keeps the value. Entries whose operands are all present leave on five typed issue ports in the same cycle, at most one per port. Each port picks the oldest ready entry that its class list admits.

Each slot is a small state machine with three states: `ENT_FREE`, `ENT_WAIT` and `ENT_READY`.
- FREE→READY (alloc-complete): the slot is written and both operands are present, counting a value that the result bus delivers in the same cycle.
- FREE→WAIT (alloc-pending): the slot is written and at least one operand is still missing.
- WAIT→READY (capture): the last missing operand is taken from the result bus.
- READY→FREE (dispatch): the slot is granted by a port.
- Any state→FREE (flush): the flush input is high.

An age matrix records which slots were written earlier. The five port pickers are chained so that a slot taken by a lower port is hidden from the ports above it.

Top module: `rs_unified`

## Requirements
- R1: After reset the station holds no entries and issues nothing. It stores up to 20 entries, and once all 20 are occupied any allocation request raises `alloc_full`.
- R2: Class codes on `alloc_cls` and `iss_cls` are 0 integer, 1 floating-point, 2 jump, 3 load address, 4 store address and 5 store data. Port 0 accepts classes 1 and 0, port 1 accepts 2 and 0, port 2 accepts 3, port 3 accepts 4 and port 4 accepts 5.
- R3: In one cycle up to five entries may issue, one per port. Bit p of `iss_valid` belongs to port p. No entry is issued twice.
- R4: An entry whose sources are not both present never issues. A broadcast with a different tag leaves it waiting.
- R5: A broadcast on `wb_valid`/`wb_tag`/`wb_data` fills every waiting source that holds that tag. The entry can issue in the cycle after the broadcast, carrying the broadcast value.
- R6: Among the ready entries that a port accepts, the one written earliest wins, whatever slot it sits in. Of two entries written in the same cycle, lane 0 counts as older.
- R7: A source that is written while the result bus carries its tag takes the broadcast value, and the entry does not miss it.
- R8: `alloc_full` is high exactly when the number of requesting lanes exceeds the number of free entries. While it is high no lane is written.
- R9: An integer entry goes to port 0 unless port 0 takes an older entry that cycle, in which case it goes to port 1. It never leaves on both ports.
- R10: Flush frees every entry at the next edge, and all issue outputs are low in the flush cycle.
- R11: An entry written with both sources present issues in the cycle after it is written, and its opcode, destination and operand values appear on the port unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all entries |
| alloc_valid | input | LANES | Allocation request per lane |
| alloc_cls | input | LANES x 3 | Operation class per lane |
| alloc_opc | input | LANES x OPC_W | Opcode per lane |
| alloc_dst | input | LANES x TAG_W | Destination tag per lane |
| alloc_a_rdy | input | LANES | Source A value present |
| alloc_a_tag | input | LANES x TAG_W | Source A producer tag |
| alloc_a_val | input | LANES x DATA_W | Source A value |
| alloc_b_rdy | input | LANES | Source B value present |
| alloc_b_tag | input | LANES x TAG_W | Source B producer tag |
| alloc_b_val | input | LANES x DATA_W | Source B value |
| alloc_full | output | 1 | Not enough free entries for this request |
| wb_valid | input | 1 | Result broadcast valid |
| wb_tag | input | TAG_W | Result tag |
| wb_data | input | DATA_W | Result value |
| iss_valid | output | 5 | Issue valid per port |
| iss_cls | output | 5 x 3 | Class of issued entry |
| iss_opc | output | 5 x OPC_W | Opcode of issued entry |
| iss_dst | output | 5 x TAG_W | Destination tag of issued entry |
| iss_a | output | 5 x DATA_W | Source A value |
| iss_b | output | 5 x DATA_W | Source B value |

## Verification
An allocation can land in the same cycle as a result broadcast that carries one of its source tags. In that case the new slot has to take the value at the moment it is written, since it will never see that broadcast again. The bench provokes this by writing an entry whose two sources both wait on a tag while that same tag is on the result bus. It writes a second entry on the other lane that waits on a different tag. The check passes when the first entry issues in the very next cycle with the broadcast value in both operands. The second entry must stay silent until its own tag is broadcast, including through an unrelated broadcast in between.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int NUM_PORTS = 5;
    localparam int CLS_W     = 3;

    typedef enum logic [2:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_JMP  = 3'd2,
        CLS_LOAD = 3'd3,
        CLS_STA  = 3'd4,
        CLS_STD  = 3'd5
    } op_cls_e;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_e;

    // Class list accepted by each issue port
    function automatic logic port_takes(input int port, input logic [2:0] cls);
        logic ok;
        ok = 1'b0;
        case (port)
            0:       ok = (cls == CLS_FP)  || (cls == CLS_INT);
            1:       ok = (cls == CLS_JMP) || (cls == CLS_INT);
            2:       ok = (cls == CLS_LOAD);
            3:       ok = (cls == CLS_STA);
            4:       ok = (cls == CLS_STD);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              wr_en,
    input  logic [CLS_W-1:0]  wr_cls,
    input  logic [OPC_W-1:0]  wr_opc,
    input  logic [TAG_W-1:0]  wr_dst,
    input  logic              wr_a_rdy,
    input  logic [TAG_W-1:0]  wr_a_tag,
    input  logic [DATA_W-1:0] wr_a_val,
    input  logic              wr_b_rdy,
    input  logic [TAG_W-1:0]  wr_b_tag,
    input  logic [DATA_W-1:0] wr_b_val,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic              dispatched,
    output logic              is_free,
    output logic              is_ready,
    output logic [CLS_W-1:0]  cls,
    output logic [OPC_W-1:0]  opc,
    output logic [TAG_W-1:0]  dst,
    output logic [DATA_W-1:0] a_val,
    output logic [DATA_W-1:0] b_val
);

    ent_state_e state_q, state_d;

    logic              a_rdy_q, b_rdy_q;
    logic [TAG_W-1:0]  a_tag_q, b_tag_q;
    logic [DATA_W-1:0] a_val_q, b_val_q;
    logic [CLS_W-1:0]  cls_q;
    logic [OPC_W-1:0]  opc_q;
    logic [TAG_W-1:0]  dst_q;

    logic byp_a, byp_b, snoop_a, snoop_b;
    logic wr_a_ok, wr_b_ok, hold_a_ok, hold_b_ok;

    always_comb begin
        byp_a     = wb_valid && !wr_a_rdy && (wr_a_tag == wb_tag);
        byp_b     = wb_valid && !wr_b_rdy && (wr_b_tag == wb_tag);
        snoop_a   = wb_valid && !a_rdy_q && (a_tag_q == wb_tag);
        snoop_b   = wb_valid && !b_rdy_q && (b_tag_q == wb_tag);
        wr_a_ok   = wr_a_rdy || byp_a;
        wr_b_ok   = wr_b_rdy || byp_b;
        hold_a_ok = a_rdy_q || snoop_a;
        hold_b_ok = b_rdy_q || snoop_b;
    end

    // next-state
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = ENT_FREE;
        end else begin
            unique case (state_q)
                ENT_FREE:  if (wr_en) state_d = (wr_a_ok && wr_b_ok) ? ENT_READY : ENT_WAIT;
                ENT_WAIT:  if (hold_a_ok && hold_b_ok) state_d = ENT_READY;
                ENT_READY: if (dispatched) state_d = ENT_FREE;
                default:   state_d = ENT_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENT_FREE;
        else        state_q <= state_d;
    end

    // payload and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_rdy_q <= 1'b0;
            b_rdy_q <= 1'b0;
            a_tag_q <= '0;
            b_tag_q <= '0;
            a_val_q <= '0;
            b_val_q <= '0;
            cls_q   <= '0;
            opc_q   <= '0;
            dst_q   <= '0;
        end else if (wr_en) begin
            cls_q   <= wr_cls;
            opc_q   <= wr_opc;
            dst_q   <= wr_dst;
            a_tag_q <= wr_a_tag;
            b_tag_q <= wr_b_tag;
            a_rdy_q <= wr_a_ok;
            b_rdy_q <= wr_b_ok;
            a_val_q <= byp_a ? wb_data : wr_a_val;
            b_val_q <= byp_b ? wb_data : wr_b_val;
        end else if (state_q == ENT_WAIT) begin
            if (snoop_a) begin
                a_rdy_q <= 1'b1;
                a_val_q <= wb_data;
            end
            if (snoop_b) begin
                b_rdy_q <= 1'b1;
                b_val_q <= wb_data;
            end
        end
    end

    // outputs
    always_comb begin
        is_free  = (state_q == ENT_FREE);
        is_ready = (state_q == ENT_READY);
        cls      = cls_q;
        opc      = opc_q;
        dst      = dst_q;
        a_val    = a_val_q;
        b_val    = b_val_q;
    end

endmodule

// File: rtl/rs_age.sv
module rs_age #(
    parameter int N_ENT = 20,
    parameter int LANES = 2,
    localparam int LW   = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_ENT-1:0]             wr_en,
    input  logic [N_ENT-1:0][LW-1:0]     wr_lane,
    output logic [N_ENT-1:0][N_ENT-1:0]  older
);

    // older[i][j] set: slot i was written before slot j
    logic [N_ENT-1:0][N_ENT-1:0] older_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            older_q <= '0;
        end else begin
            for (int i = 0; i < N_ENT; i++) begin
                for (int j = 0; j < N_ENT; j++) begin
                    if (i != j) begin
                        if (wr_en[i] && wr_en[j]) older_q[i][j] <= (wr_lane[i] < wr_lane[j]);
                        else if (wr_en[i])        older_q[i][j] <= 1'b0;
                        else if (wr_en[j])        older_q[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    assign older = older_q;

endmodule

// File: rtl/rs_picker.sv
module rs_picker
    import rs_pkg::*;
#(
    parameter int N_ENT = 20,
    parameter int PORT  = 0
) (
    input  logic [N_ENT-1:0]             ready,
    input  logic [N_ENT-1:0][CLS_W-1:0]  cls,
    input  logic [N_ENT-1:0][N_ENT-1:0]  older,
    input  logic [N_ENT-1:0]             taken_in,
    output logic [N_ENT-1:0]             grant,
    output logic [N_ENT-1:0]             taken_out
);

    logic [N_ENT-1:0] cand;
    logic [N_ENT-1:0] blocked;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            cand[i] = ready[i] && !taken_in[i] && port_takes(PORT, cls[i]);
        end
        blocked = '0;
        for (int i = 0; i < N_ENT; i++) begin
            for (int j = 0; j < N_ENT; j++) begin
                if (j != i && cand[j] && older[j][i]) blocked[i] = 1'b1;
            end
        end
        grant     = cand & ~blocked;
        taken_out = taken_in | grant;
    end

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
    parameter int N_ENT = 20,
    parameter int LANES = 2,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic                      flush,
    input  logic [LANES-1:0]          alloc_valid,
    input  logic [N_ENT-1:0]          is_free,
    output logic [N_ENT-1:0]          wr_en,
    output logic [N_ENT-1:0][LW-1:0]  wr_lane,
    output logic                      full,
    output logic [CNT_W-1:0]          free_cnt
);

    logic [CNT_W-1:0] req_cnt;
    logic [N_ENT-1:0] avail;
    logic             found;

    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < N_ENT; i++) free_cnt = free_cnt + CNT_W'(is_free[i]);
        req_cnt = '0;
        for (int l = 0; l < LANES; l++) req_cnt = req_cnt + CNT_W'(alloc_valid[l]);
        full = (req_cnt > free_cnt);

        avail   = is_free;
        wr_en   = '0;
        wr_lane = '0;
        found   = 1'b0;
        for (int l = 0; l < LANES; l++) begin
            found = 1'b0;
            if (alloc_valid[l] && !full && !flush) begin
                for (int i = 0; i < N_ENT; i++) begin
                    if (!found && avail[i]) begin
                        wr_en[i]   = 1'b1;
                        wr_lane[i] = LW'(l);
                        avail[i]   = 1'b0;
                        found      = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rs_unified.sv
module rs_unified
    import rs_pkg::*;
#(
    parameter int N_ENT  = 20,
    parameter int LANES  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16,
    parameter int OPC_W  = 4,
    localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               flush,
    input  logic [LANES-1:0]                   alloc_valid,
    input  logic [LANES-1:0][CLS_W-1:0]        alloc_cls,
    input  logic [LANES-1:0][OPC_W-1:0]        alloc_opc,
    input  logic [LANES-1:0][TAG_W-1:0]        alloc_dst,
    input  logic [LANES-1:0]                   alloc_a_rdy,
    input  logic [LANES-1:0][TAG_W-1:0]        alloc_a_tag,
    input  logic [LANES-1:0][DATA_W-1:0]       alloc_a_val,
    input  logic [LANES-1:0]                   alloc_b_rdy,
    input  logic [LANES-1:0][TAG_W-1:0]        alloc_b_tag,
    input  logic [LANES-1:0][DATA_W-1:0]       alloc_b_val,
    output logic                               alloc_full,
    input  logic                               wb_valid,
    input  logic [TAG_W-1:0]                   wb_tag,
    input  logic [DATA_W-1:0]                  wb_data,
    output logic [NUM_PORTS-1:0]               iss_valid,
    output logic [NUM_PORTS-1:0][CLS_W-1:0]    iss_cls,
    output logic [NUM_PORTS-1:0][OPC_W-1:0]    iss_opc,
    output logic [NUM_PORTS-1:0][TAG_W-1:0]    iss_dst,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   iss_a,
    output logic [NUM_PORTS-1:0][DATA_W-1:0]   iss_b
);

    logic [N_ENT-1:0]              is_free, is_ready, ready_g, dispatched;
    logic [N_ENT-1:0]              wr_en;
    logic [N_ENT-1:0][LW-1:0]      wr_lane;
    logic [N_ENT-1:0][N_ENT-1:0]   older;
    logic [N_ENT-1:0][CLS_W-1:0]   e_cls;
    logic [N_ENT-1:0][OPC_W-1:0]   e_opc;
    logic [N_ENT-1:0][TAG_W-1:0]   e_dst;
    logic [N_ENT-1:0][DATA_W-1:0]  e_a, e_b;
    logic [CNT_W-1:0]              free_cnt;
    logic [N_ENT-1:0]              grant [NUM_PORTS];
    logic [N_ENT-1:0]              taken [NUM_PORTS+1];

    rs_alloc #(.N_ENT(N_ENT), .LANES(LANES)) u_alloc (
        .flush       (flush),
        .alloc_valid (alloc_valid),
        .is_free     (is_free),
        .wr_en       (wr_en),
        .wr_lane     (wr_lane),
        .full        (alloc_full),
        .free_cnt    (free_cnt)
    );

    rs_age #(.N_ENT(N_ENT), .LANES(LANES)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_lane (wr_lane),
        .older   (older)
    );

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        rs_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W), .OPC_W(OPC_W)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .flush      (flush),
            .wr_en      (wr_en[g]),
            .wr_cls     (alloc_cls[wr_lane[g]]),
            .wr_opc     (alloc_opc[wr_lane[g]]),
            .wr_dst     (alloc_dst[wr_lane[g]]),
            .wr_a_rdy   (alloc_a_rdy[wr_lane[g]]),
            .wr_a_tag   (alloc_a_tag[wr_lane[g]]),
            .wr_a_val   (alloc_a_val[wr_lane[g]]),
            .wr_b_rdy   (alloc_b_rdy[wr_lane[g]]),
            .wr_b_tag   (alloc_b_tag[wr_lane[g]]),
            .wr_b_val   (alloc_b_val[wr_lane[g]]),
            .wb_valid   (wb_valid),
            .wb_tag     (wb_tag),
            .wb_data    (wb_data),
            .dispatched (dispatched[g]),
            .is_free    (is_free[g]),
            .is_ready   (is_ready[g]),
            .cls        (e_cls[g]),
            .opc        (e_opc[g]),
            .dst        (e_dst[g]),
            .a_val      (e_a[g]),
            .b_val      (e_b[g])
        );
    end

    assign ready_g  = flush ? '0 : is_ready;
    assign taken[0] = '0;

    // lower ports choose first and hide their pick from higher ports
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        rs_picker #(.N_ENT(N_ENT), .PORT(p)) u_pick (
            .ready     (ready_g),
            .cls       (e_cls),
            .older     (older),
            .taken_in  (taken[p]),
            .grant     (grant[p]),
            .taken_out (taken[p+1])
        );
    end

    assign dispatched = taken[NUM_PORTS];

    always_comb begin
        for (int p = 0; p < NUM_PORTS; p++) begin
            iss_valid[p] = |grant[p];
            iss_cls[p]   = '0;
            iss_opc[p]   = '0;
            iss_dst[p]   = '0;
            iss_a[p]     = '0;
            iss_b[p]     = '0;
            for (int i = 0; i < N_ENT; i++) begin
                if (grant[p][i]) begin
                    iss_cls[p] = e_cls[i];
                    iss_opc[p] = e_opc[i];
                    iss_dst[p] = e_dst[i];
                    iss_a[p]   = e_a[i];
                    iss_b[p]   = e_b[i];
                end
            end
        end
    end

endmodule

// File: rtl/rs_unified_chk.sv
module rs_unified_chk
    import rs_pkg::*;
#(
    parameter int N_ENT = 20,
    localparam int CNT_W = $clog2(N_ENT + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             flush,
    input  logic                             alloc_full,
    input  logic [CNT_W-1:0]                 free_cnt,
    input  logic [NUM_PORTS-1:0]             iss_valid,
    input  logic [NUM_PORTS-1:0][CLS_W-1:0]  iss_cls,
    input  logic [N_ENT-1:0]                 grant [NUM_PORTS]
);

    logic bad_cls;
    logic dup;

    always_comb begin
        bad_cls = 1'b0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (iss_valid[p] && !port_takes(p, iss_cls[p])) bad_cls = 1'b1;
        end
        dup = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int q = p + 1; q < NUM_PORTS; q++) begin
                    if (grant[p][i] && grant[q][i]) dup = 1'b1;
                end
            end
        end
    end

    p_port_class_r2: assert property (@(posedge clk) disable iff (!rst_n) !bad_cls);

    p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n) !dup);

    p_int_low_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid[1] && iss_cls[1] == CLS_INT) |-> iss_valid[0]);

    p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_cnt == CNT_W'(N_ENT)) && (iss_valid == '0));

    p_stall_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_full |=> free_cnt >= $past(free_cnt));

endmodule

bind rs_unified rs_unified_chk #(.N_ENT(N_ENT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_full (alloc_full),
    .free_cnt   (free_cnt),
    .iss_valid  (iss_valid),
    .iss_cls    (iss_cls),
    .grant      (grant)
);

// File: tb/rs_unified_bench.sv
module rs_unified_bench;

    localparam int N  = 20;
    localparam int L  = 2;
    localparam int TW = 6;
    localparam int DW = 16;
    localparam int OW = 4;
    localparam int P  = 5;

    localparam logic [2:0] C_INT = 3'd0, C_FP = 3'd1, C_JMP = 3'd2,
                           C_LD = 3'd3, C_STA = 3'd4, C_STD = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [L-1:0]          alloc_valid = '0;
    logic [L-1:0][2:0]     alloc_cls = '0;
    logic [L-1:0][OW-1:0]  alloc_opc = '0;
    logic [L-1:0][TW-1:0]  alloc_dst = '0;
    logic [L-1:0]          alloc_a_rdy = '0;
    logic [L-1:0][TW-1:0]  alloc_a_tag = '0;
    logic [L-1:0][DW-1:0]  alloc_a_val = '0;
    logic [L-1:0]          alloc_b_rdy = '0;
    logic [L-1:0][TW-1:0]  alloc_b_tag = '0;
    logic [L-1:0][DW-1:0]  alloc_b_val = '0;
    logic                  alloc_full;
    logic                  wb_valid = 1'b0;
    logic [TW-1:0]         wb_tag = '0;
    logic [DW-1:0]         wb_data = '0;
    logic [P-1:0]          iss_valid;
    logic [P-1:0][2:0]     iss_cls;
    logic [P-1:0][OW-1:0]  iss_opc;
    logic [P-1:0][TW-1:0]  iss_dst;
    logic [P-1:0][DW-1:0]  iss_a;
    logic [P-1:0][DW-1:0]  iss_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rs_unified #(.N_ENT(N), .LANES(L), .TAG_W(TW), .DATA_W(DW), .OPC_W(OW)) u_rs_unified (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_cls(alloc_cls), .alloc_opc(alloc_opc),
        .alloc_dst(alloc_dst), .alloc_a_rdy(alloc_a_rdy), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_rdy(alloc_b_rdy), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .alloc_full(alloc_full),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .iss_valid(iss_valid), .iss_cls(iss_cls), .iss_opc(iss_opc),
        .iss_dst(iss_dst), .iss_a(iss_a), .iss_b(iss_b)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic lane(input int l, input logic [2:0] cls, input int dst,
                        input logic ar, input int at, input int av,
                        input logic br, input int bt, input int bv);
        alloc_valid[l] = 1'b1;
        alloc_cls[l]   = cls;
        alloc_opc[l]   = OW'(dst);
        alloc_dst[l]   = TW'(dst);
        alloc_a_rdy[l] = ar;
        alloc_a_tag[l] = TW'(at);
        alloc_a_val[l] = DW'(av);
        alloc_b_rdy[l] = br;
        alloc_b_tag[l] = TW'(bt);
        alloc_b_val[l] = DW'(bv);
    endtask

    task automatic idle();
        alloc_valid = '0;
        wb_valid    = 1'b0;
    endtask

    task automatic bcast(input int t, input int d);
        wb_valid = 1'b1;
        wb_tag   = TW'(t);
        wb_data  = DW'(d);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check("R1", "issue after reset", iss_valid, 0);
        lane(0, C_INT, 1, 1, 0, 0, 1, 0, 0);
        lane(1, C_INT, 2, 1, 0, 0, 1, 0, 0);
        #1;
        check("R1", "full after reset", alloc_full, 0);
        idle();

        // fill the pool with twenty integer entries all waiting on tag 7
        for (int c = 0; c < 10; c++) begin
            lane(0, C_INT, 2*c,   0, 7, 0, 1, 0, 2*c);
            lane(1, C_INT, 2*c+1, 0, 7, 0, 1, 0, 2*c+1);
            #1;
            if (c == 9) check("R8", "full with two free two requested", alloc_full, 0);
            tick();
            check("R4", "pending entries stay", iss_valid, 0);
        end
        idle();
        lane(0, C_INT, 63, 1, 0, 5, 1, 0, 5);
        #1;
        check("R1", "full with twenty held", alloc_full, 1);
        tick();
        idle();
        check("R8", "stalled request not written", iss_valid, 0);

        // broadcast wakes all twenty; they drain two per cycle in age order
        bcast(7, 'h1234);
        tick();
        idle();
        for (int c = 0; c < 10; c++) begin
            check("R5", "port0 valid after wake", iss_valid[0], 1);
            check("R6", "port0 oldest dst", iss_dst[0], 2*c);
            check("R9", "port1 next int dst", iss_dst[1], 2*c+1);
            check("R5", "captured value", iss_a[0], 'h1234);
            check("R11", "held b value", iss_b[1], 2*c+1);
            tick();
        end
        check("R1", "drained", iss_valid, 0);

        // one of every non-integer class, released together
        lane(0, C_FP,  30, 0, 8, 0, 1, 0, 0);
        lane(1, C_JMP, 31, 0, 8, 0, 1, 0, 0);
        tick();
        lane(0, C_LD,  32, 0, 8, 0, 1, 0, 0);
        lane(1, C_STA, 33, 0, 8, 0, 1, 0, 0);
        tick();
        idle();
        lane(0, C_STD, 34, 0, 8, 0, 1, 0, 0);
        tick();
        idle();
        check("R4", "typed entries waiting", iss_valid, 0);
        bcast(8, 'h55);
        tick();
        idle();
        check("R3", "five ports at once", iss_valid, 5'h1F);
        for (int p = 0; p < P; p++) begin
            check("R2", "port class", iss_cls[p], (p == 0) ? 1 : p + 1);
            check("R2", "port dst", iss_dst[p], 30 + p);
        end
        tick();
        check("R3", "no second issue", iss_valid, 0);

        // single integer goes to port 0 only
        lane(0, C_INT, 40, 1, 0, 1, 1, 0, 2);
        tick();
        idle();
        check("R9", "lone int port0 only", iss_valid, 5'h01);
        check("R11", "opcode passthrough", iss_opc[0], 40 % 16);
        check("R11", "dst passthrough", iss_dst[0], 40);
        tick();
        check("R9", "lone int not reissued", iss_valid, 0);

        // older FP takes port 0, int moves to port 1
        lane(0, C_FP,  41, 1, 0, 1, 1, 0, 1);
        lane(1, C_INT, 42, 1, 0, 1, 1, 0, 1);
        tick();
        idle();
        check("R9", "fp and int split", iss_valid, 5'h03);
        check("R9", "port0 fp dst", iss_dst[0], 41);
        check("R9", "port1 int dst", iss_dst[1], 42);
        tick();

        // same-cycle lanes: lane 0 is older
        lane(0, C_INT, 43, 1, 0, 1, 1, 0, 1);
        lane(1, C_INT, 44, 1, 0, 1, 1, 0, 1);
        tick();
        idle();
        check("R6", "lane0 on port0", iss_dst[0], 43);
        check("R6", "lane1 on port1", iss_dst[1], 44);
        tick();

        // older but not ready does not block younger ready
        lane(0, C_INT, 45, 0, 10, 0, 1, 0, 0);
        tick();
        idle();
        lane(0, C_INT, 46, 1, 0, 1, 1, 0, 1);
        tick();
        idle();
        check("R4", "younger ready goes alone", iss_valid, 5'h01);
        check("R4", "younger dst", iss_dst[0], 46);
        bcast(10, 'h77);
        tick();
        idle();
        check("R5", "woken dst", iss_dst[0], 45);
        check("R5", "woken value", iss_a[0], 'h77);
        tick();

        // age beats slot index
        lane(0, C_INT, 47, 0, 16, 0, 1, 0, 0);
        lane(1, C_INT, 48, 0, 17, 0, 1, 0, 0);
        tick();
        idle();
        bcast(16, 3);
        tick();
        idle();
        check("R5", "tag16 wake", iss_dst[0], 47);
        tick();
        lane(0, C_INT, 50, 0, 17, 0, 1, 0, 0);
        tick();
        idle();
        lane(0, C_INT, 51, 0, 17, 0, 1, 0, 0);
        tick();
        idle();
        bcast(17, 9);
        tick();
        idle();
        check("R6", "oldest in higher slot wins", iss_dst[0], 48);
        check("R6", "second oldest port1", iss_dst[1], 50);
        tick();
        check("R6", "youngest last", iss_valid, 5'h01);
        check("R6", "youngest dst", iss_dst[0], 51);
        tick();
        check("R6", "all gone", iss_valid, 0);

        // bypass on write while the tag is broadcast
        lane(0, C_INT, 52, 0, 11, 0, 0, 11, 0);
        lane(1, C_INT, 53, 0, 12, 0, 1, 0, 4);
        bcast(11, 'h0BEE);
        tick();
        idle();
        check("R7", "bypassed entry issues", iss_valid, 5'h01);
        check("R7", "bypassed dst", iss_dst[0], 52);
        check("R7", "bypassed a", iss_a[0], 'h0BEE);
        check("R7", "bypassed b", iss_b[0], 'h0BEE);
        tick();
        check("R4", "other lane still waits", iss_valid, 0);
        bcast(13, 1);
        tick();
        idle();
        check("R4", "unrelated tag ignored", iss_valid, 0);
        bcast(12, 'h22);
        tick();
        idle();
        check("R5", "late wake dst", iss_dst[0], 53);
        check("R5", "late wake value", iss_a[0], 'h22);
        tick();

        // flush
        lane(0, C_INT, 60, 0, 14, 0, 1, 0, 0);
        lane(1, C_INT, 61, 0, 14, 0, 1, 0, 0);
        tick();
        idle();
        lane(0, C_INT, 62, 1, 0, 1, 1, 0, 1);
        tick();
        idle();
        check("R11", "ready entry before flush", iss_dst[0], 62);
        flush = 1'b1;
        #1;
        check("R10", "quiet during flush", iss_valid, 0);
        tick();
        flush = 1'b0;
        bcast(14, 5);
        tick();
        idle();
        check("R10", "flushed entries gone", iss_valid, 0);
        tick();
        check("R10", "still empty", iss_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule